// File: doc/BRIEF.md
# Read-Write Sharing Bypass Controller

This block keeps cache lines that are written by one node and read by another out of a large DRAM cache level, so that such lines live only in the last-level SRAM caches. It has two halves. The home half holds a directory table where each entry has a coherence state and a sticky sharing flag. That flag is raised at run time whenever an incoming coherence request finds the entry Modified and forces the owner to give up or write back its copy. Every read or write miss answered by the home half carries a bypass bit equal to the entry's sharing flag after the update.

The requester half stores the bypass bit beside each last-level line when the line is filled. When the fill arrives from a DRAM-cache miss, the bit decides whether the line may also be installed in the DRAM cache. When the line is later evicted, the bit decides where the eviction goes. Dirty lines with the bit set go to main memory. Dirty lines without the bit are written into the DRAM cache. Clean evictions produce no write at all. Carrying the response across the network is not part of this block: the bench connects the response port to the fill port.

Top module: `rws_bypass_ctrl`

## Requirements
- R1: While reset is asserted, ev_ready, rsp_valid, dc_fill_valid, wb_mem_valid and wb_dc_valid are all 0. After reset every directory entry is Invalid with its sharing flag clear.
- R2: The directory state is encoded I=2'b00, S=2'b01, M=2'b10. The ev_op encoding is read=2'b00, write=2'b01, flush=2'b10, free=2'b11. A read moves the entry to S and a write moves it to M. A flush moves M to S and leaves I or S unchanged. A free moves the entry to I.
- R3: A read that finds the entry in M (a forward to the owner) sets the sharing flag.
- R4: A write that finds the entry in M (invalidation of the owner) sets the sharing flag. A write that finds it in I or S does not set it.
- R5: A flush that finds the entry in M sets the sharing flag. A flush of an entry in I or S has no effect on the flag.
- R6: The sharing flag stays set across all later reads, writes and flushes. Only a free clears it.
- R7: Each accepted read or write produces exactly one response in the next cycle, with rsp_idx equal to the request index, rsp_state equal to the new state and rsp_bypass equal to the sharing flag after the update. Flush and free produce no response.
- R8: ev_ready is 1 from the first cycle after reset, so one event is accepted per cycle. A cycle with ev_valid low changes no entry and produces no response.
- R9: A fill with fill_bypass=0 raises dc_fill_valid with dc_fill_line equal to the line in the next cycle. A fill with fill_bypass=1 produces no DRAM-cache fill.
- R10: A dirty eviction of a line whose stored bypass bit is 1 raises wb_mem_valid (and not wb_dc_valid) in the next cycle, with wb_line equal to the line.
- R11: A dirty eviction of a line whose stored bypass bit is 0 raises wb_dc_valid (and not wb_mem_valid) in the next cycle, with wb_line equal to the line.
- R12: A clean eviction raises neither wb_mem_valid nor wb_dc_valid, whatever the stored bit.
- R13: A refill of a line replaces the stored bypass bit, so a later eviction is routed by the most recent fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Coherence event present |
| ev_ready | output | 1 | Event can be accepted |
| ev_op | input | 2 | Event kind: read, write, flush, free |
| ev_idx | input | DIR_W | Directory entry index |
| rsp_valid | output | 1 | Miss response present |
| rsp_idx | output | DIR_W | Entry the response belongs to |
| rsp_state | output | 2 | Entry state after the update |
| rsp_bypass | output | 1 | Bypass bit carried with the data |
| fill_valid | input | 1 | Last-level line fill |
| fill_line | input | LINE_W | Last-level line index being filled |
| fill_bypass | input | 1 | Bypass bit arriving with the fill |
| dc_fill_valid | output | 1 | Install the filled line in the DRAM cache |
| dc_fill_line | output | LINE_W | Line for the DRAM-cache install |
| evict_valid | input | 1 | Last-level eviction |
| evict_line | input | LINE_W | Line being evicted |
| evict_dirty | input | 1 | Evicted line is dirty |
| wb_mem_valid | output | 1 | Write the evicted line to main memory |
| wb_dc_valid | output | 1 | Write the evicted line into the DRAM cache |
| wb_line | output | LINE_W | Line of the routed writeback |

## Verification
The hardest case to reach from the ports is a sharing flag that must survive many later operations and then clear on a free. The flag cannot be read directly. It is only seen through the bypass bit of later miss responses, and a flush or free gives no response at all. So the stimulus first drives an entry into M and triggers a forward, an invalidation or a flush. It then issues follow-up reads and writes whose responses expose the flag, and a free followed by a read shows the flag is cleared. A long pseudo-random mix of all four operations over a few entries, issued back to back, is compared against a reference model in the scoreboard.

// File: rtl/rwsb_pkg.sv
package rwsb_pkg;

  typedef enum logic [1:0] {
    DS_I = 2'b00,
    DS_S = 2'b01,
    DS_M = 2'b10
  } dstate_e;

  typedef enum logic [1:0] {
    OP_RD    = 2'b00,
    OP_WR    = 2'b01,
    OP_FLUSH = 2'b10,
    OP_FREE  = 2'b11
  } evop_e;

  typedef struct packed {
    dstate_e st;
    logic    rws;
  } dent_t;

  // next entry value for one coherence event
  function automatic dent_t dir_next(dent_t cur, evop_e op);
    dent_t n;
    n = cur;
    case (op)
      OP_RD: begin
        n.st  = DS_S;
        n.rws = cur.rws | (cur.st == DS_M);
      end
      OP_WR: begin
        n.st  = DS_M;
        n.rws = cur.rws | (cur.st == DS_M);
      end
      OP_FLUSH: begin
        if (cur.st == DS_M) begin
          n.st  = DS_S;
          n.rws = 1'b1;
        end
      end
      default: begin
        n.st  = DS_I;
        n.rws = 1'b0;
      end
    endcase
    return n;
  endfunction

  function automatic logic op_answers(evop_e op);
    return (op == OP_RD) || (op == OP_WR);
  endfunction

endpackage

// File: rtl/rwsb_home_dir.sv
module rwsb_home_dir
  import rwsb_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_valid,
  output logic             ev_ready,
  input  logic [1:0]       ev_op,
  input  logic [IDX_W-1:0] ev_idx,
  output logic             rsp_valid,
  output logic [IDX_W-1:0] rsp_idx,
  output logic [1:0]       rsp_state,
  output logic             rsp_bypass
);

  dent_t tbl [ENTRIES];
  logic  ready_q;

  evop_e op;
  logic  ev_accept;
  dent_t cur_ent;
  dent_t nxt_ent;
  logic  rws_raise;

  assign op        = evop_e'(ev_op);
  assign ev_ready  = ready_q;
  assign ev_accept = ev_valid && ready_q;
  assign cur_ent   = tbl[ev_idx];
  assign nxt_ent   = dir_next(cur_ent, op);
  assign rws_raise = ev_accept && !cur_ent.rws && nxt_ent.rws;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ready_q    <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_idx    <= '0;
      rsp_state  <= DS_I;
      rsp_bypass <= 1'b0;
      for (int i = 0; i < ENTRIES; i++) tbl[i] <= '{st: DS_I, rws: 1'b0};
    end else begin
      ready_q   <= 1'b1;
      rsp_valid <= ev_accept && op_answers(op);
      if (ev_accept) begin
        tbl[ev_idx] <= nxt_ent;
        rsp_idx     <= ev_idx;
        rsp_state   <= nxt_ent.st;
        rsp_bypass  <= nxt_ent.rws;
      end
    end
  end

  a_r7_rsp_after_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_accept && op_answers(op)) |=> (rsp_valid && rsp_idx == $past(ev_idx)));

  a_r3_fwd_sets_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_accept && op == OP_RD && cur_ent.st == DS_M) |=> rsp_bypass);

  a_r6_free_no_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_accept && op == OP_FREE) |=> !rsp_valid);

  a_r8_idle_no_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_accept |=> !rsp_valid);

  a_r4_raise_only_from_m: assert property (@(posedge clk) disable iff (!rst_n)
    rws_raise |-> (cur_ent.st == DS_M));

endmodule

// File: rtl/rwsb_llc_tags.sv
module rwsb_llc_tags #(
  parameter int LINES = 32,
  localparam int LINE_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fill_valid,
  input  logic [LINE_W-1:0] fill_line,
  input  logic              fill_bypass,
  input  logic              evict_valid,
  input  logic [LINE_W-1:0] evict_line,
  output logic              evict_byp,
  output logic              dc_fill_valid,
  output logic [LINE_W-1:0] dc_fill_line
);

  logic [LINES-1:0] byp_q;
  logic             dc_allowed;

  assign evict_byp  = byp_q[evict_line];
  assign dc_allowed = fill_valid && !fill_bypass;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      byp_q         <= '0;
      dc_fill_valid <= 1'b0;
      dc_fill_line  <= '0;
    end else begin
      if (evict_valid) byp_q[evict_line] <= 1'b0;
      if (fill_valid)  byp_q[fill_line]  <= fill_bypass;
      dc_fill_valid <= dc_allowed;
      if (dc_allowed) dc_fill_line <= fill_line;
    end
  end

  a_r9_bypass_no_dc_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && fill_bypass) |=> !dc_fill_valid);

  a_r13_refill_wins: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |=> (byp_q[$past(fill_line)] == $past(fill_bypass)));

endmodule

// File: rtl/rwsb_evict_router.sv
module rwsb_evict_router #(
  parameter int LINE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evict_valid,
  input  logic [LINE_W-1:0] evict_line,
  input  logic              evict_dirty,
  input  logic              evict_byp,
  output logic              wb_mem_valid,
  output logic              wb_dc_valid,
  output logic [LINE_W-1:0] wb_line
);

  logic to_mem;
  logic to_dc;

  assign to_mem = evict_valid && evict_dirty && evict_byp;
  assign to_dc  = evict_valid && evict_dirty && !evict_byp;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wb_mem_valid <= 1'b0;
      wb_dc_valid  <= 1'b0;
      wb_line      <= '0;
    end else begin
      wb_mem_valid <= to_mem;
      wb_dc_valid  <= to_dc;
      if (to_mem || to_dc) wb_line <= evict_line;
    end
  end

  a_r10_one_target: assert property (@(posedge clk) disable iff (!rst_n)
    !(wb_mem_valid && wb_dc_valid));

  a_r12_clean_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (evict_valid && !evict_dirty) |=> (!wb_mem_valid && !wb_dc_valid));

endmodule

// File: rtl/rws_bypass_ctrl.sv
module rws_bypass_ctrl #(
  parameter int DIR_ENTRIES = 16,
  parameter int LLC_LINES   = 32,
  localparam int DIR_W  = $clog2(DIR_ENTRIES),
  localparam int LINE_W = $clog2(LLC_LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  output logic              ev_ready,
  input  logic [1:0]        ev_op,
  input  logic [DIR_W-1:0]  ev_idx,
  output logic              rsp_valid,
  output logic [DIR_W-1:0]  rsp_idx,
  output logic [1:0]        rsp_state,
  output logic              rsp_bypass,
  input  logic              fill_valid,
  input  logic [LINE_W-1:0] fill_line,
  input  logic              fill_bypass,
  output logic              dc_fill_valid,
  output logic [LINE_W-1:0] dc_fill_line,
  input  logic              evict_valid,
  input  logic [LINE_W-1:0] evict_line,
  input  logic              evict_dirty,
  output logic              wb_mem_valid,
  output logic              wb_dc_valid,
  output logic [LINE_W-1:0] wb_line
);

  logic evict_byp;

  rwsb_home_dir #(.ENTRIES(DIR_ENTRIES)) u_home (
    .clk(clk), .rst_n(rst_n),
    .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_op(ev_op), .ev_idx(ev_idx),
    .rsp_valid(rsp_valid), .rsp_idx(rsp_idx), .rsp_state(rsp_state),
    .rsp_bypass(rsp_bypass)
  );

  rwsb_llc_tags #(.LINES(LLC_LINES)) u_tags (
    .clk(clk), .rst_n(rst_n),
    .fill_valid(fill_valid), .fill_line(fill_line), .fill_bypass(fill_bypass),
    .evict_valid(evict_valid), .evict_line(evict_line), .evict_byp(evict_byp),
    .dc_fill_valid(dc_fill_valid), .dc_fill_line(dc_fill_line)
  );

  rwsb_evict_router #(.LINE_W(LINE_W)) u_route (
    .clk(clk), .rst_n(rst_n),
    .evict_valid(evict_valid), .evict_line(evict_line),
    .evict_dirty(evict_dirty), .evict_byp(evict_byp),
    .wb_mem_valid(wb_mem_valid), .wb_dc_valid(wb_dc_valid), .wb_line(wb_line)
  );

endmodule

// File: tb/rws_bypass_ctrl_tb.sv
module rws_bypass_ctrl_tb;

  localparam int DW = 4;
  localparam int LW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic ev_valid = 0, ev_ready;
  logic [1:0] ev_op = 0;
  logic [DW-1:0] ev_idx = 0;
  logic rsp_valid, rsp_bypass;
  logic [DW-1:0] rsp_idx;
  logic [1:0] rsp_state;
  logic fill_valid = 0, fill_bypass = 0;
  logic [LW-1:0] fill_line = 0;
  logic dc_fill_valid;
  logic [LW-1:0] dc_fill_line;
  logic evict_valid = 0, evict_dirty = 0;
  logic [LW-1:0] evict_line = 0;
  logic wb_mem_valid, wb_dc_valid;
  logic [LW-1:0] wb_line;

  rws_bypass_ctrl u_dut (.*);

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference model of the directory, built from R2..R6
  logic [1:0] m_st  [16];
  logic       m_rws [16];
  typedef struct { logic [DW-1:0] idx; logic [1:0] st; logic byp; string tag; } exp_t;
  exp_t sb[$];

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic send(logic [1:0] op, logic [DW-1:0] idx, string tag);
    logic [1:0] s;
    logic r;
    @(negedge clk);
    ev_valid = 1; ev_op = op; ev_idx = idx;
    @(posedge clk);
    s = m_st[idx]; r = m_rws[idx];
    if (op == 2'b00)      begin m_rws[idx] = r | (s == 2'b10); m_st[idx] = 2'b01; end
    else if (op == 2'b01) begin m_rws[idx] = r | (s == 2'b10); m_st[idx] = 2'b10; end
    else if (op == 2'b10) begin if (s == 2'b10) begin m_st[idx] = 2'b01; m_rws[idx] = 1; end end
    else                  begin m_st[idx] = 2'b00; m_rws[idx] = 0; end
    if (op[1] == 1'b0) sb.push_back('{idx, m_st[idx], m_rws[idx], tag});
  endtask

  task automatic idle(int n);
    @(negedge clk);
    ev_valid = 0; fill_valid = 0; evict_valid = 0;
    repeat (n) @(negedge clk);
  endtask

  // monitor: compare every response with the scoreboard
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (sb.size() == 0) check(0, "R7", "unexpected response", 1, 0);
      else begin
        exp_t e;
        e = sb.pop_front();
        check(rsp_idx == e.idx, e.tag, "rsp_idx", rsp_idx, e.idx);
        check(rsp_state == e.st, e.tag, "rsp_state", rsp_state, e.st);
        check(rsp_bypass == e.byp, e.tag, "rsp_bypass", rsp_bypass, e.byp);
      end
    end
  end

  task automatic fill(logic [LW-1:0] ln, logic b, string tag);
    @(negedge clk);
    fill_valid = 1; fill_line = ln; fill_bypass = b;
    @(negedge clk);
    fill_valid = 0;
    check(dc_fill_valid == !b, tag, "dc_fill_valid", dc_fill_valid, !b);
    if (!b) check(dc_fill_line == ln, tag, "dc_fill_line", dc_fill_line, ln);
  endtask

  task automatic evict(logic [LW-1:0] ln, logic d, logic expb, string tag);
    @(negedge clk);
    evict_valid = 1; evict_line = ln; evict_dirty = d;
    @(negedge clk);
    evict_valid = 0;
    check(wb_mem_valid == (d && expb), tag, "wb_mem_valid", wb_mem_valid, d && expb);
    check(wb_dc_valid == (d && !expb), tag, "wb_dc_valid", wb_dc_valid, d && !expb);
    if (d) check(wb_line == ln, tag, "wb_line", wb_line, ln);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin m_st[i] = 2'b00; m_rws[i] = 0; end
    repeat (3) @(negedge clk);
    check(ev_ready == 0, "R1", "ev_ready in reset", ev_ready, 0);
    check(!rsp_valid && !dc_fill_valid, "R1", "outputs in reset", rsp_valid, 0);
    check(!wb_mem_valid && !wb_dc_valid, "R1", "wb in reset", wb_mem_valid, 0);
    rst_n = 1;
    @(negedge clk);
    check(ev_ready == 1, "R8", "ev_ready after reset", ev_ready, 1);

    // R2 / R4 / R3 / R6 on entry 0
    send(2'b00, 0, "R1");
    send(2'b00, 0, "R2");
    send(2'b01, 0, "R4");
    send(2'b00, 0, "R3");
    send(2'b01, 0, "R6");
    send(2'b11, 0, "R6");
    send(2'b00, 0, "R6");
    // R4 from I then from M
    send(2'b01, 1, "R4");
    send(2'b01, 1, "R4");
    // R5 flush of M
    send(2'b01, 2, "R5");
    send(2'b10, 2, "R5");
    send(2'b00, 2, "R5");
    // R5 flush of S and I has no effect
    send(2'b00, 3, "R5");
    send(2'b10, 3, "R5");
    send(2'b10, 5, "R5");
    send(2'b00, 3, "R5");
    send(2'b01, 5, "R5");
    idle(2);
    // R8 invalid cycle ignored
    @(negedge clk);
    ev_valid = 0; ev_op = 2'b01; ev_idx = 4;
    @(negedge clk);
    @(negedge clk);
    check(rsp_valid == 0, "R8", "rsp on idle cycle", rsp_valid, 0);
    send(2'b00, 4, "R8");
    // R7 back-to-back random mix
    begin
      logic [7:0] lf;
      lf = 8'h5a;
      for (int k = 0; k < 60; k++) begin
        lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
        send(lf[1:0], DW'(8 + lf[4:2] % 3), "R7");
      end
    end
    idle(3);
    check(sb.size() == 0, "R7", "responses outstanding", sb.size(), 0);

    // requester side
    fill(3, 0, "R9");
    fill(4, 1, "R9");
    evict(4, 1, 1, "R10");
    evict(3, 1, 0, "R11");
    fill(5, 1, "R12");
    evict(5, 0, 1, "R12");
    fill(7, 0, "R12");
    evict(7, 0, 0, "R12");
    fill(6, 1, "R13");
    fill(6, 0, "R13");
    evict(6, 1, 0, "R13");
    fill(9, 0, "R13");
    fill(9, 1, "R13");
    evict(9, 1, 1, "R13");
    idle(2);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

endmodule